// File: doc/BRIEF.md
# FIFO-Buffered Serial Transmitter

This block turns a stream of bytes into an asynchronous serial character stream. Bytes enter through a single-cycle write port into a 128-entry queue. The byte at the head of the queue is moved into an 8-bit shift register whenever the transmitter is free. A controller then sends the character on `txd`. The timing comes from an external strobe, `tick16`, which pulses once per sixteenth of a bit period. The block does not make the baud rate; the surrounding logic supplies the strobe.

The line format is set on four configuration inputs: data length from 5 to 8 bits, parity on or off, odd or even parity, and one or two stop bits. The format is captured when a byte is moved into the shift register, so a format change affects only characters loaded after it. Three flags report progress. `fifo_empty` means no byte is waiting in the queue. `tx_idle` means the queue is empty and the shift register has finished its last stop bit. `fifo_full` means further writes will be dropped.

The controller has five states:
- IDLE: the line is held high. When the queue is not empty, it takes a byte (transition load) and goes to START.
- START: after one bit time it goes to DATA.
- DATA: it shifts one data bit per bit time. After the last data bit it goes to PARITY if parity is on, otherwise to STOP.
- PARITY: after one bit time it goes to STOP.
- STOP: after one bit time, when two stop bits are selected and only the first has been sent, it stays in STOP for a second bit time. Otherwise it reloads and goes straight to START if the queue holds a byte, or it returns to IDLE.

Top module: `fifo_serial_tx`

## Requirements
- R1: During and after reset with no writes, `txd` is 1, `fifo_empty` is 1, `tx_idle` is 1 and `fifo_full` is 0; the line stays at 1 in IDLE.
- R2: Each character is sent in this order: a start bit at 0, the data bits least significant first, the parity bit when enabled, then the stop bit(s) at 1. Bytes leave in the order they were written.
- R3: `cfg_len` selects the number of data bits as 5 plus its value (0 gives 5 bits, 3 gives 8 bits). Only the low bits of the byte are sent.
- R4: When `cfg_par_en` is 1, a parity bit follows the data bits. With `cfg_par_odd` at 0 (even), it equals the XOR of the data bits sent. With `cfg_par_odd` at 1 (odd), it is the inverse of that XOR. When `cfg_par_en` is 0, no parity bit is sent.
- R5: `cfg_stop2` at 0 gives one stop bit, and at 1 gives two stop bits, each at 1.
- R6: Every bit lasts exactly 16 `tick16` pulses. While a character is in flight, `txd` does not change on a clock edge without a `tick16` pulse.
- R7: When the queue holds a byte at the end of the last stop bit, the next start bit begins at once. Consecutive start bits are therefore exactly 16 × (1 + data bits + parity bit + stop bits) ticks apart.
- R8: The queue holds 128 bytes in addition to the one in the shift register. A write while `fifo_full` is 1 is dropped. `fifo_full` and `fifo_empty` are never 1 together.
- R9: `fifo_empty` becomes 1 as soon as the last waiting byte moves into the shift register, while that character is still being sent.
- R10: `tx_idle` is 0 while any character is being sent, including during its final stop bit. It becomes 1 only when a stop bit ends with the queue empty.
- R11: The line format is captured when a byte is loaded into the shift register. Changing the configuration inputs during a character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the byte queue |
| wr_data | input | 8 | Byte to queue |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one stop bit |
| txd | output | 1 | Serial line, idles high |
| fifo_empty | output | 1 | No byte waiting in the queue |
| fifo_full | output | 1 | Queue cannot accept a write |
| tx_idle | output | 1 | Queue empty and last character finished |

## Verification
A wrong bit counter or a missed state shows up on `txd` within the same character. A frame that is one bit too long or too short moves every later sample by 16 ticks. The receiving model then sees a wrong data, parity or stop bit, and it does so inside one character time. A corrupted queue pointer or count shows up as a missing, repeated or reordered byte in the decoded stream, or as `fifo_full` at the wrong write. The long burst that wraps the pointers reaches that case within one pass through the 128 entries.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } line_cfg_t;

    localparam int MIN_DATA_BITS = 5;

endpackage

// File: rtl/ftx_fifo.sv
module ftx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_q;
    logic [AW-1:0]    rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic             do_push;
    logic             do_pop;

    assign full    = (count_q == CW'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = wr_en && !full;
    assign do_pop  = rd_en && !empty;
    assign rd_data = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/ftx_bit_timer.sv
module ftx_bit_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic bit_done
);
    localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(OSR - 1);

    logic [TW-1:0] cnt_q;

    assign bit_done = run && tick && (cnt_q == LAST_TICK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= bit_done ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter
    import ftx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  line_cfg_t         load_cfg,
    input  logic              shift,
    output logic              ser_bit,
    output logic              par_bit,
    output logic              last_data,
    output logic              par_en_q,
    output logic              stop2_q
);
    localparam int IW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sr_q;
    logic [IW-1:0]     idx_q;
    logic [IW-1:0]     nbits_q;
    logic [IW-1:0]     nbits_in;
    logic              par_calc;
    logic              par_q;

    assign nbits_in = IW'(MIN_DATA_BITS) + IW'(load_cfg.len_code);

    always_comb begin
        par_calc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (IW'(i) < nbits_in) begin
                par_calc = par_calc ^ load_data[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q     <= '0;
            idx_q    <= '0;
            nbits_q  <= IW'(DATA_W);
            par_q    <= 1'b0;
            par_en_q <= 1'b0;
            stop2_q  <= 1'b0;
        end else if (load) begin
            sr_q     <= load_data;
            idx_q    <= '0;
            nbits_q  <= nbits_in;
            par_q    <= par_calc ^ load_cfg.par_odd;
            par_en_q <= load_cfg.par_en;
            stop2_q  <= load_cfg.stop2;
        end else if (shift) begin
            sr_q  <= sr_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign ser_bit   = sr_q[0];
    assign par_bit   = par_q;
    assign last_data = (idx_q == nbits_q - 1'b1);

endmodule

// File: rtl/fifo_serial_tx.sv
module fifo_serial_tx
    import ftx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int OSR        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick16,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    output logic              txd,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              tx_idle
);
    tx_state_e         state_q;
    tx_state_e         state_d;
    logic              stop_sec_q;
    logic              stop_sec_d;
    logic              load_char;
    logic              shift_bit;
    logic              bit_done;
    logic [DATA_W-1:0] head_data;
    logic              ser_bit;
    logic              par_bit;
    logic              last_data;
    logic              par_en_q;
    logic              stop2_q;
    line_cfg_t         cfg_in;

    assign cfg_in = '{len_code: cfg_len, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, stop2: cfg_stop2};

    ftx_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (load_char),
        .rd_data (head_data),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    ftx_bit_timer #(
        .OSR (OSR)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .restart  (load_char),
        .tick     (tick16),
        .bit_done (bit_done)
    );

    ftx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_char),
        .load_data (head_data),
        .load_cfg  (cfg_in),
        .shift     (shift_bit),
        .ser_bit   (ser_bit),
        .par_bit   (par_bit),
        .last_data (last_data),
        .par_en_q  (par_en_q),
        .stop2_q   (stop2_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            stop_sec_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            stop_sec_q <= stop_sec_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_d    = state_q;
        stop_sec_d = stop_sec_q;
        load_char  = 1'b0;
        shift_bit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    load_char = 1'b1;
                    state_d   = ST_START;
                end
            end
            ST_START: begin
                if (bit_done) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_done) begin
                    if (last_data) begin
                        state_d = par_en_q ? ST_PARITY : ST_STOP;
                    end else begin
                        shift_bit = 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_done) begin
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (bit_done) begin
                    if (stop2_q && !stop_sec_q) begin
                        stop_sec_d = 1'b1;
                    end else begin
                        stop_sec_d = 1'b0;
                        if (!fifo_empty) begin
                            load_char = 1'b1;
                            state_d   = ST_START;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            default: begin
                state_d    = ST_IDLE;
                stop_sec_d = 1'b0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = ser_bit;
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
        tx_idle = (state_q == ST_IDLE) && fifo_empty;
    end

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker
    import ftx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick16,
    input logic      wr_en,
    input logic      txd,
    input logic      fifo_empty,
    input logic      fifo_full,
    input logic      tx_idle,
    input logic      load_char,
    input tx_state_e state_q
);

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> txd);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> !txd);

    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> txd);

    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !tick16) |=> $stable(txd));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && !load_char) |=> fifo_full);

    a_r9_empty_by_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_empty) |-> $past(load_char));

    a_r10_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_idle) |-> $past(state_q == ST_STOP));

endmodule

bind fifo_serial_tx ftx_checker u_ftx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .wr_en      (wr_en),
    .txd        (txd),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .tx_idle    (tx_idle),
    .load_char  (load_char),
    .state_q    (state_q)
);

// File: tb/fifo_serial_tx_test.sv
module fifo_serial_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;

    typedef struct {
        logic [7:0] data;
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic       st2;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick16 = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       txd;
    logic       fifo_empty;
    logic       fifo_full;
    logic       tx_idle;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   tick_div = 0;
    int   tdiv_cnt = 0;
    bit   mon_busy = 1'b0;
    int   prev_start = -1;
    int   last_gap = 0;
    bit   done = 1'b0;

    // monitor working variables
    exp_t       m_e;
    int         m_nb;
    logic [7:0] m_got;
    logic [7:0] m_want;
    logic       m_bit;
    logic       m_par;

    fifo_serial_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .tick16      (tick16),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop2   (cfg_stop2),
        .txd         (txd),
        .fifo_empty  (fifo_empty),
        .fifo_full   (fifo_full),
        .tx_idle     (tx_idle)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick16   <= 1'b0;
            tdiv_cnt <= 0;
        end else if (tdiv_cnt >= tick_div - 1) begin
            tick16   <= 1'b1;
            tdiv_cnt <= 0;
        end else begin
            tick16   <= 1'b0;
            tdiv_cnt <= tdiv_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (tick16) c++;
        end
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic pen,
                           input logic podd, input logic st2);
        cfg_len = len;
        cfg_par_en = pen;
        cfg_par_odd = podd;
        cfg_stop2 = st2;
    endtask

    // Driver: one write; pushes the expected item when acceptance is expected.
    task automatic put_byte(input logic [7:0] d, input bit accept);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        if (accept) begin
            e.data = d;
            e.len = cfg_len;
            e.pen = cfg_par_en;
            e.podd = cfg_par_odd;
            e.st2 = cfg_stop2;
            exp_q.push_back(e);
        end
    endtask

    task automatic end_write();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (mon_busy || !tx_idle || exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: decodes frames on txd and compares against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                mon_busy = 1'b1;
                if (prev_start >= 0) last_gap = cyc - prev_start;
                prev_start = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "frame with no queued byte", 1, 0);
                    m_e.data = 8'h00; m_e.len = 2'd3; m_e.pen = 1'b0;
                    m_e.podd = 1'b0; m_e.st2 = 1'b0;
                end else begin
                    m_e = exp_q.pop_front();
                end
                m_nb = 5 + int'(m_e.len);
                wait_ticks(OSR / 2);
                @(negedge clk);
                check(txd === 1'b0, "R2", "start bit", int'(txd), 0);
                m_got = '0;
                m_want = '0;
                m_par = m_e.podd;
                for (int i = 0; i < m_nb; i++) begin
                    wait_ticks(OSR);
                    @(negedge clk);
                    m_got[i] = txd;
                    m_want[i] = m_e.data[i];
                    m_par = m_par ^ m_e.data[i];
                end
                check(m_got === m_want, "R3", "data bits lsb first",
                      int'(m_got), int'(m_want));
                if (m_e.pen) begin
                    wait_ticks(OSR);
                    @(negedge clk);
                    check(txd === m_par, "R4", "parity bit", int'(txd), int'(m_par));
                end
                wait_ticks(OSR);
                @(negedge clk);
                check(txd === 1'b1, "R5", "first stop bit", int'(txd), 1);
                if (m_e.st2) begin
                    wait_ticks(OSR);
                    @(negedge clk);
                    check(txd === 1'b1, "R5", "second stop bit", int'(txd), 1);
                end
                check(tx_idle === 1'b0, "R10", "busy during last stop", int'(tx_idle), 0);
                mon_busy = 1'b0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
        check(fifo_empty === 1'b1, "R1", "fifo_empty in reset", int'(fifo_empty), 1);
        check(tx_idle === 1'b1, "R1", "tx_idle in reset", int'(tx_idle), 1);
        check(fifo_full === 1'b0, "R1", "fifo_full in reset", int'(fifo_full), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(txd === 1'b1, "R1", "txd idle after reset", int'(txd), 1);

        // R9 / R10 / R6: one byte, ticks stopped
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        tick_div = 0;
        put_byte(8'h3C, 1'b1);
        end_write();
        repeat (2) @(negedge clk);
        check(fifo_empty === 1'b1, "R9", "empty once byte in shifter", int'(fifo_empty), 1);
        check(tx_idle === 1'b0, "R10", "not idle while sending", int'(tx_idle), 0);
        repeat (40) @(negedge clk);
        check(txd === 1'b0, "R6", "start held without ticks", int'(txd), 0);
        tick_div = 1;
        wait_done();
        check(tx_idle === 1'b1, "R10", "idle after last stop", int'(tx_idle), 1);

        // R3 / R4 / R5: format sweep
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    set_cfg(2'(ln), pm != 0, pm == 2, st == 1);
                    put_byte(8'(8'hA5 ^ (ln * 37 + pm * 11 + st * 5)), 1'b1);
                    put_byte(8'(8'h5B + ln * 19 + pm * 7 + st), 1'b1);
                    end_write();
                    wait_done();
                end
            end
        end

        // R7: back-to-back spacing, 8 data, even parity, 1 stop, tick every cycle
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        tick_div = 1;
        prev_start = -1;
        put_byte(8'h11, 1'b1);
        put_byte(8'h22, 1'b1);
        put_byte(8'h33, 1'b1);
        end_write();
        wait_done();
        check(last_gap == OSR * 11, "R7", "start-to-start cycles 8E1", last_gap, OSR * 11);

        // R6: bit length with tick every third cycle, 8 data, odd parity, 2 stops
        set_cfg(2'd3, 1'b1, 1'b1, 1'b1);
        tick_div = 3;
        prev_start = -1;
        put_byte(8'hF0, 1'b1);
        put_byte(8'h0F, 1'b1);
        put_byte(8'h96, 1'b1);
        end_write();
        wait_done();
        check(last_gap == 3 * OSR * 12, "R6", "start-to-start cycles 8O2", last_gap, 3 * OSR * 12);

        // R11: change format after load
        tick_div = 0;
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        put_byte(8'hC3, 1'b1);
        end_write();
        repeat (3) @(negedge clk);
        set_cfg(2'd0, 1'b1, 1'b0, 1'b1);
        tick_div = 1;
        wait_done();
        put_byte(8'h5A, 1'b1);
        end_write();
        wait_done();
        check(exp_q.size() == 0, "R11", "both formats decoded", exp_q.size(), 0);

        // R8: burst of 131 writes with line stopped; 129 fit
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        tick_div = 0;
        for (int i = 0; i < 131; i++) begin
            put_byte(8'(i * 29 + 7), i < 129);
        end
        end_write();
        check(fifo_full === 1'b1, "R8", "full after 129 writes", int'(fifo_full), 1);
        check(fifo_empty === 1'b0, "R8", "not empty when full", int'(fifo_empty), 0);
        tick_div = 1;
        wait_done();
        check(fifo_full === 1'b0, "R8", "full cleared after drain", int'(fifo_full), 0);
        check(txd === 1'b1, "R1", "line high after drain", int'(txd), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule